// File: doc/BRIEF.md
# BCD Calendar Time Counter

This block keeps wall-clock minutes, hours, day of month and month as packed BCD fields. It advances by one minute each time a minute-carry input from the seconds prescaler drops from high to low, and rolls each field over into the next. The day field uses the current month to pick its last day. February always ends on the 28th. The 29th exists only when a host writes it, and from the 29th the next day is 1 March. Leap-year policy is left to host software.

A host load port can set any single field directly, one field per cycle, and that load overrides an advance of the same field. The four fields are packed into one 24-bit word for an alarm comparator further down the chip.

Top module: `calTimeCounter`

## Requirements
- R1: After reset the fields read minute 00, hour 00, day 01, month 01.
- R2: A one-minute advance happens only in the cycle where `minCarry` is sampled low after being sampled high in the previous cycle. A rising edge, a held high level and a held low level cause no change.
- R3: Minutes count in BCD from 00 to 59. After 59 the next advance gives 00 and carries into hours. The ones digit rolls 9 to 0 and carries into the tens digit.
- R4: Hours count in BCD from 00 to 23. A carry on hour 23 gives 00 and carries into days.
- R5: In months 04, 06, 09 and 11, day 30 is followed by 01, with a carry into months. In months 01, 03, 05, 07, 08, 10 and 12, day 31 is followed by 01, with a carry into months. Earlier days step by one.
- R6: In month 02, day 28 is followed by 01 and month 03. A day of 29 that a host loaded is followed by 01 and month 03.
- R7: Months count in BCD from 01 to 12, and 12 is followed by 01.
- R8: A host load with `wrEn` high writes `wrData` into the field chosen by `wrSel` (0 minutes, 1 hours, 2 days, 3 months), using its low 7, 6, 6 or 5 bits. The new value appears after the next clock edge and overrides an advance of that field in the same cycle.
- R9: `timeWord` packs the fields as month in bits 23:19, day in bits 18:13, hour in bits 12:7 and minute in bits 6:0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| minCarry | input | 1 | Minute carry level; a high-to-low change advances one minute |
| wrEn | input | 1 | Host load enable |
| wrSel | input | 2 | Field select for a load |
| wrData | input | 7 | BCD value to load |
| timeWord | output | 24 | Packed {month, day, hour, minute} |

## Verification
Each vector loads a start time and applies one advance. The starting points include:
- a mid-hour minute, which exercises the BCD ones-to-tens carry;
- minute 59 with hours not at their end;
- 23:59 on the last day of a 30-day month, a 31-day month, February on the 28th and a loaded 29th, and December;
- 23:59 on the day before each of those limits, which separates a wrong limit table from a wrong increment.

Directed sequences drive `minCarry` through rising edges, held levels and falling edges to show that only the falling edge counts. They also collide a load with an advance to show which one wins.

// File: rtl/calTypes_pkg.sv
package calTypes_pkg;
  localparam int DIGIT_W     = 4;
  localparam int MIN_TENS_W  = 3;
  localparam int HOUR_TENS_W = 2;
  localparam int DAY_TENS_W  = 2;
  localparam int MON_TENS_W  = 1;
  localparam int MIN_W  = MIN_TENS_W + DIGIT_W;
  localparam int HOUR_W = HOUR_TENS_W + DIGIT_W;
  localparam int DAY_W  = DAY_TENS_W + DIGIT_W;
  localparam int MON_W  = MON_TENS_W + DIGIT_W;
  localparam int WORD_W = MIN_W + HOUR_W + DAY_W + MON_W;
  localparam int FIELDS = 4;
  localparam int SEL_W  = $clog2(FIELDS);
  localparam int DATA_W = MIN_W;

  typedef enum logic [SEL_W-1:0] {
    FLD_MIN   = 2'd0,
    FLD_HOUR  = 2'd1,
    FLD_DAY   = 2'd2,
    FLD_MONTH = 2'd3
  } calField_e;

  typedef struct packed {
    logic              tick;
    logic [FIELDS-1:0] wrField;
    logic [DATA_W-1:0] wrData;
  } calStrobe_t;
endpackage

// File: rtl/calBcdField.sv
module calBcdField
  import calTypes_pkg::*;
#(
  parameter int                    TENS_W = 3,
  parameter logic [TENS_W+DIGIT_W-1:0] FIRST = '0
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        advance,
  input  logic [TENS_W+DIGIT_W-1:0]   lastVal,
  input  logic                        wrEn,
  input  logic [TENS_W+DIGIT_W-1:0]   wrVal,
  output logic [TENS_W+DIGIT_W-1:0]   value,
  output logic                        atLast
);
  localparam int W = TENS_W + DIGIT_W;

  logic [DIGIT_W-1:0] onesDigit;
  logic [TENS_W-1:0]  tensDigit;
  logic [W-1:0]       incVal;

  assign onesDigit = value[DIGIT_W-1:0];
  assign tensDigit = value[W-1:DIGIT_W];
  assign atLast    = (value >= lastVal);

  always_comb begin
    if (onesDigit >= DIGIT_W'(9)) incVal = {tensDigit + TENS_W'(1), DIGIT_W'(0)};
    else                          incVal = {tensDigit, onesDigit + DIGIT_W'(1)};
  end

  always_ff @(posedge clk) begin
    if (!rstN)        value <= FIRST;
    else if (wrEn)    value <= wrVal;
    else if (advance) value <= atLast ? FIRST : incVal;
  end

  // R8: a load always lands, whatever the advance does
  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rstN)
    wrEn |=> value == $past(wrVal));
endmodule

// File: rtl/calControl.sv
module calControl
  import calTypes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              minCarry,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  output calStrobe_t        strobes
);
  logic carryPrev;

  always_ff @(posedge clk) begin
    if (!rstN) carryPrev <= 1'b0;
    else       carryPrev <= minCarry;
  end

  assign strobes.tick   = carryPrev & ~minCarry;
  assign strobes.wrData = wrData;

  for (genvar i = 0; i < FIELDS; i++) begin : g_sel
    assign strobes.wrField[i] = wrEn && (wrSel == SEL_W'(i));
  end

  // R2: two advances never come from back-to-back cycles
  p_single_tick_r2: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick |=> !strobes.tick);
  // R8: a load reaches at most one field
  p_one_field_r8: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0(strobes.wrField));
endmodule

// File: rtl/calDatapath.sv
module calDatapath
  import calTypes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  calStrobe_t        strobes,
  output logic [WORD_W-1:0] timeWord
);
  logic [MIN_W-1:0]  minVal;
  logic [HOUR_W-1:0] hourVal;
  logic [DAY_W-1:0]  dayVal;
  logic [MON_W-1:0]  monVal;
  logic [DAY_W-1:0]  dayLast;
  logic minLast, hourLast, dayAtLast, monLast;
  logic hourAdv, dayAdv, monAdv;

  assign hourAdv = strobes.tick & minLast;
  assign dayAdv  = hourAdv & hourLast;
  assign monAdv  = dayAdv & dayAtLast;

  always_comb begin
    unique case (monVal)
      5'h02:                      dayLast = (dayVal == 6'h29) ? 6'h29 : 6'h28;
      5'h04, 5'h06, 5'h09, 5'h11: dayLast = 6'h30;
      default:                    dayLast = 6'h31;
    endcase
  end

  calBcdField #(.TENS_W(MIN_TENS_W), .FIRST(7'h00)) u_min (
    .clk(clk), .rstN(rstN), .advance(strobes.tick), .lastVal(7'h59),
    .wrEn(strobes.wrField[FLD_MIN]), .wrVal(strobes.wrData[MIN_W-1:0]),
    .value(minVal), .atLast(minLast));

  calBcdField #(.TENS_W(HOUR_TENS_W), .FIRST(6'h00)) u_hour (
    .clk(clk), .rstN(rstN), .advance(hourAdv), .lastVal(6'h23),
    .wrEn(strobes.wrField[FLD_HOUR]), .wrVal(strobes.wrData[HOUR_W-1:0]),
    .value(hourVal), .atLast(hourLast));

  calBcdField #(.TENS_W(DAY_TENS_W), .FIRST(6'h01)) u_day (
    .clk(clk), .rstN(rstN), .advance(dayAdv), .lastVal(dayLast),
    .wrEn(strobes.wrField[FLD_DAY]), .wrVal(strobes.wrData[DAY_W-1:0]),
    .value(dayVal), .atLast(dayAtLast));

  calBcdField #(.TENS_W(MON_TENS_W), .FIRST(5'h01)) u_mon (
    .clk(clk), .rstN(rstN), .advance(monAdv), .lastVal(5'h12),
    .wrEn(strobes.wrField[FLD_MONTH]), .wrVal(strobes.wrData[MON_W-1:0]),
    .value(monVal), .atLast(monLast));

  assign timeWord = {monVal, dayVal, hourVal, minVal};

  logic noLoad;
  assign noLoad = (strobes.wrField == '0);

  p_min_wrap_r3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick && noLoad && minVal == 7'h59 |=> minVal == 7'h00);
  p_hour_wrap_r4: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick && noLoad && minVal == 7'h59 && hourVal == 6'h23 |=> hourVal == 6'h00);
  p_feb_wrap_r6: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick && noLoad && minVal == 7'h59 && hourVal == 6'h23 &&
    monVal == 5'h02 && dayVal == 6'h28 |=> dayVal == 6'h01 && monVal == 5'h03);
  p_year_wrap_r7: assert property (@(posedge clk) disable iff (!rstN)
    strobes.tick && noLoad && minVal == 7'h59 && hourVal == 6'h23 &&
    monVal == 5'h12 && dayVal == 6'h31 |=> monVal == 5'h01);
  p_idle_hold_r2: assert property (@(posedge clk) disable iff (!rstN)
    !strobes.tick && noLoad |=> $stable(timeWord));
endmodule

// File: rtl/calTimeCounter.sv
module calTimeCounter
  import calTypes_pkg::*;
(
  input  logic              clk,
  input  logic              rstN,
  input  logic              minCarry,
  input  logic              wrEn,
  input  logic [SEL_W-1:0]  wrSel,
  input  logic [DATA_W-1:0] wrData,
  output logic [WORD_W-1:0] timeWord
);
  calStrobe_t strobes;

  calControl u_ctrl (
    .clk(clk), .rstN(rstN), .minCarry(minCarry), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .strobes(strobes));

  calDatapath u_dp (
    .clk(clk), .rstN(rstN), .strobes(strobes), .timeWord(timeWord));
endmodule

// File: tb/calTimeCounter_bench.sv
module calTimeCounter_bench;
  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic minCarry = 1'b0;
  logic wrEn = 1'b0;
  logic [1:0] wrSel = '0;
  logic [6:0] wrData = '0;
  logic [23:0] timeWord;
  int checks = 0;
  int fails = 0;
  bit done = 0;

  always #10 clk = ~clk;

  calTimeCounter u_calTimeCounter (
    .clk(clk), .rstN(rstN), .minCarry(minCarry), .wrEn(wrEn),
    .wrSel(wrSel), .wrData(wrData), .timeWord(timeWord));

  // start month, day, hour, minute; expected month, day, hour, minute
  localparam int NV = 17;
  localparam logic [63:0] VEC [NV] = '{
    64'h01_01_00_00_01_01_00_01,  // R3 simple step
    64'h01_01_00_09_01_01_00_10,  // R3 ones to tens
    64'h03_15_05_59_03_15_06_00,  // R3 minute wrap
    64'h03_15_23_59_03_16_00_00,  // R4 hour wrap
    64'h04_30_23_59_05_01_00_00,  // R5 30-day month
    64'h05_30_23_59_05_31_00_00,  // R5 31-day month, not last
    64'h07_31_23_59_08_01_00_00,  // R5 31-day month end
    64'h02_28_23_59_03_01_00_00,  // R6 Feb 28 end
    64'h02_29_23_59_03_01_00_00,  // R6 loaded 29th end
    64'h01_28_23_59_01_29_00_00,  // R5 28 outside Feb
    64'h12_31_23_59_01_01_00_00,  // R7 year wrap
    64'h11_30_23_59_12_01_00_00,  // R5 Nov
    64'h09_30_23_59_10_01_00_00,  // R5 Sep
    64'h02_27_23_59_02_28_00_00,  // R6 before limit
    64'h06_29_23_59_06_30_00_00,  // R5 before limit
    64'h10_31_12_59_10_31_13_00,  // R4 mid-day hour step
    64'h02_28_22_59_02_28_23_00   // R4 no day carry
  };

  function automatic logic [23:0] pack(input logic [7:0] mo, dy, hr, mi);
    return {mo[4:0], dy[5:0], hr[5:0], mi[6:0]};
  endfunction

  task automatic check(input logic [23:0] expv, input string tag);
    checks++;
    if (timeWord !== expv) begin
      fails++;
      $display("FAIL %s: timeWord=%h expected=%h", tag, timeWord, expv);
    end
  endtask

  task automatic load(input logic [7:0] mo, dy, hr, mi);
    logic [7:0] vals [4];
    vals = '{mi, hr, dy, mo};
    for (int f = 0; f < 4; f++) begin
      @(negedge clk);
      wrEn = 1'b1; wrSel = 2'(f); wrData = vals[f][6:0];
    end
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic tick();
    @(negedge clk); minCarry = 1'b1;
    @(negedge clk); minCarry = 1'b0;
    @(negedge clk);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    check(pack(8'h01, 8'h01, 8'h00, 8'h00), "R1 reset state");

    for (int v = 0; v < NV; v++) begin
      load(VEC[v][63:56], VEC[v][55:48], VEC[v][47:40], VEC[v][39:32]);
      check(pack(VEC[v][63:56], VEC[v][55:48], VEC[v][47:40], VEC[v][39:32]), "R8 load");
      tick();
      check(pack(VEC[v][31:24], VEC[v][23:16], VEC[v][15:8], VEC[v][7:0]), "R3-R7 vector");
    end

    // R9 bit layout
    load(8'h11, 8'h22, 8'h13, 8'h45);
    checks++;
    if (timeWord[23:19] !== 5'h11 || timeWord[18:13] !== 6'h22 ||
        timeWord[12:7] !== 6'h13 || timeWord[6:0] !== 7'h45) begin
      fails++;
      $display("FAIL R9: timeWord=%h expected=%h", timeWord, 24'h8c49c5);
    end

    // R2 rising edge and held levels
    load(8'h03, 8'h10, 8'h08, 8'h20);
    @(negedge clk); minCarry = 1'b1;
    @(negedge clk);
    check(pack(8'h03, 8'h10, 8'h08, 8'h20), "R2 rising edge ignored");
    repeat (4) @(negedge clk);
    check(pack(8'h03, 8'h10, 8'h08, 8'h20), "R2 high level ignored");
    minCarry = 1'b0;
    @(negedge clk);
    check(pack(8'h03, 8'h10, 8'h08, 8'h21), "R2 falling edge advances");
    repeat (4) @(negedge clk);
    check(pack(8'h03, 8'h10, 8'h08, 8'h21), "R2 low level ignored");

    // R3 run of advances across an hour
    load(8'h03, 8'h10, 8'h00, 8'h55);
    for (int k = 0; k < 10; k++) tick();
    check(pack(8'h03, 8'h10, 8'h01, 8'h05), "R3 ten advances");

    // R8 load collides with advance on the same field
    load(8'h03, 8'h10, 8'h08, 8'h05);
    @(negedge clk); minCarry = 1'b1;
    @(negedge clk); minCarry = 1'b0; wrEn = 1'b1; wrSel = 2'd0; wrData = 7'h30;
    @(negedge clk); wrEn = 1'b0;
    check(pack(8'h03, 8'h10, 8'h08, 8'h30), "R8 load beats advance");

    // R1 reset again from a loaded state
    rstN = 1'b0;
    @(negedge clk); rstN = 1'b1;
    @(negedge clk);
    check(pack(8'h01, 8'h01, 8'h00, 8'h00), "R1 reset after use");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: done=0 expected=1");
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end
endmodule